// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Segment

This block is a stretch of a boundary-scan register that wraps a group of bidirectional pads and a few capture-only pins. Every pad owns three cells in the chain: a control cell that decides whether the test path drives the pad, an output cell that holds the test data value, and an input cell that observes the pad. Capture-only cells follow the pads. They record a dedicated pin and have no drive path, because that pin always acts directly on the device. The block is clocked by the test clock. The TAP controller supplies capture, shift and update strobes and a two-bit instruction mode.

In the functional and sampling modes the pads carry the core's output value and enable unchanged. In the external and internal test modes the update latches drive the pads. In the internal test mode they also feed the core's input. Capture is selective. The external test mode loads only the input cells. The internal test mode loads only the control and output cells. When a pad is not driven, the block reports which weak pull it would fall to, and one global input swaps the pull direction for every pad.

Top module: `bscan_io_segment`

## Requirements
- R1: Pad i occupies chain cells 3i (control), 3i+1 (output) and 3i+2 (input), and capture-only cell j sits at cell 3·NUM_PADS+j. A shift cycle (shift_dr=1, capture_dr=0) moves every cell one place toward scan_out, loads scan_in into the highest cell, and scan_out always shows cell 0.
- R2: A synchronous reset sets every control cell, in both its shift stage and its update latch, to 1 and every other cell to 0. After reset the test modes therefore leave all pads undriven.
- R3: mode_sel encodes 00 functional, 01 sample, 10 external test, 11 internal test. In 00 and 01, pad_out equals core_out, pad_oe equals core_oe and core_in equals pad_in.
- R4: A capture cycle in mode 00 or 01 loads each control cell with the inverse of core_oe, each output cell with core_out and each input cell with pad_in.
- R5: A capture cycle in mode 10 loads only the input cells, from pad_in. The control and output cells keep their contents.
- R6: A capture cycle in mode 11 loads the control cells with the inverse of core_oe and the output cells with core_out. The input cells keep their contents.
- R7: On a falling test-clock edge with update_dr=1, every update latch takes its shift stage. At any other time the latches hold. In modes 10 and 11, pad_oe is the inverse of the control latch (1 means disabled) and pad_out is the output latch.
- R8: In mode 11, core_in is the input cell's update latch. In every other mode it is pad_in.
- R9: A pad with pad_oe=0 reports pad_pull_dn=1 when pull_swap=0 and pad_pull_up=1 when pull_swap=1. A driven pad reports neither.
- R10: Capture-only cells load obs_pin in every mode, and their contents reach no pad or core output.
- R11: A cycle with neither capture nor shift leaves every shift stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Instruction mode (00 func, 01 sample, 10 ext test, 11 int test) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe, acted on at the falling edge |
| scan_in | input | 1 | Serial data into the highest cell |
| scan_out | output | 1 | Serial data from cell 0 |
| pull_swap | input | 1 | Reports pull-up instead of pull-down for undriven pads |
| core_out | input | NUM_PADS | Core output values |
| core_oe | input | NUM_PADS | Core output enables, 1 drives |
| core_in | output | NUM_PADS | Values delivered to the core |
| pad_out | output | NUM_PADS | Values driven to the pads |
| pad_oe | output | NUM_PADS | Pad drive enables, 1 drives |
| pad_in | input | NUM_PADS | Values sensed at the pads |
| pad_pull_up | output | NUM_PADS | Undriven pad falls to the weak pull-up |
| pad_pull_dn | output | NUM_PADS | Undriven pad falls to the weak pull-down |
| obs_pin | input | NUM_OBS | Capture-only dedicated pins |

## Verification
The bench targets the mode-dependent capture masks. A design that loads every cell on capture would overwrite the data staged for the external test with the core's values, and that shows up when the chain is shifted back out. The sweeps also cover the inversion between the control cell and the enable, so a design that drives pads whose control bit is 1 fails on the first update. Two further checks cover the reset state of the control latches and the pull report under both swap settings. A design that resets the controls to 0 would drive every pad as soon as a test mode is entered, and a pull report tied to the wrong polarity flips between the two flags.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_EXTEST = 2'b10,
    MODE_INTEST = 2'b11
  } bscan_mode_e;

  localparam int CELLS_PER_PAD = 3;
  localparam int SLOT_CTL      = 0;
  localparam int SLOT_OUT      = 1;
  localparam int SLOT_IN       = 2;

  // Test modes hand the pads to the update latches.
  function automatic logic test_owns_pads(input bscan_mode_e m);
    return (m == MODE_EXTEST) || (m == MODE_INTEST);
  endfunction

endpackage

// File: rtl/bscan_pad_cells.sv
`timescale 1ns/1ps
module bscan_pad_cells
  import bscan_pkg::*;
(
  input  logic        tck,
  input  logic        rst,
  input  bscan_mode_e mode,
  input  logic        capture_dr,
  input  logic        shift_dr,
  input  logic        update_dr,
  input  logic        chain_in,
  input  logic        pull_swap,
  input  logic        core_out,
  input  logic        core_oe,
  output logic        core_in,
  output logic        pad_out,
  output logic        pad_oe,
  input  logic        pad_in,
  output logic        pull_up,
  output logic        pull_dn,
  output logic [CELLS_PER_PAD-1:0] cell_q
);

  localparam logic [CELLS_PER_PAD-1:0] SAFE_VAL = CELLS_PER_PAD'(1) << SLOT_CTL;

  logic [CELLS_PER_PAD-1:0] sr_q;
  logic [CELLS_PER_PAD-1:0] upd_q;
  logic                     keep_drive;
  logic                     keep_sense;

  // External test freezes the drive cells, internal test freezes the sense cell.
  assign keep_drive = (mode == MODE_EXTEST);
  assign keep_sense = (mode == MODE_INTEST);

  always_ff @(posedge tck) begin
    if (rst) begin
      sr_q <= SAFE_VAL;
    end else if (capture_dr) begin
      if (!keep_drive) begin
        sr_q[SLOT_CTL] <= ~core_oe;
        sr_q[SLOT_OUT] <= core_out;
      end
      if (!keep_sense) begin
        sr_q[SLOT_IN] <= pad_in;
      end
    end else if (shift_dr) begin
      sr_q <= {chain_in, sr_q[CELLS_PER_PAD-1:1]};
    end
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      upd_q <= SAFE_VAL;
    end else if (update_dr) begin
      upd_q <= sr_q;
    end
  end

  always_comb begin
    if (test_owns_pads(mode)) begin
      pad_oe  = ~upd_q[SLOT_CTL];
      pad_out = upd_q[SLOT_OUT];
    end else begin
      pad_oe  = core_oe;
      pad_out = core_out;
    end
    core_in = keep_sense ? upd_q[SLOT_IN] : pad_in;
    pull_up = ~pad_oe & pull_swap;
    pull_dn = ~pad_oe & ~pull_swap;
  end

  assign cell_q = sr_q;

endmodule

// File: rtl/bscan_obs_cell.sv
`timescale 1ns/1ps
module bscan_obs_cell (
  input  logic tck,
  input  logic rst,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic chain_in,
  input  logic obs_pin,
  output logic cell_q
);

  logic sr_q;

  // Capture in every mode; nothing downstream of this cell is driven.
  always_ff @(posedge tck) begin
    if (rst) begin
      sr_q <= 1'b0;
    end else if (capture_dr) begin
      sr_q <= obs_pin;
    end else if (shift_dr) begin
      sr_q <= chain_in;
    end
  end

  assign cell_q = sr_q;

endmodule

// File: rtl/bscan_io_segment.sv
`timescale 1ns/1ps
module bscan_io_segment
  import bscan_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int NUM_OBS  = 2
) (
  input  logic                tck,
  input  logic                rst,
  input  logic [1:0]          mode_sel,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic                pull_swap,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_pull_up,
  output logic [NUM_PADS-1:0] pad_pull_dn,
  input  logic [NUM_OBS-1:0]  obs_pin
);

  localparam int PAD_CELLS = CELLS_PER_PAD * NUM_PADS;
  localparam int CHAIN_LEN = PAD_CELLS + NUM_OBS;

  bscan_mode_e           mode;
  logic [CHAIN_LEN-1:0]  chain_q;
  logic [NUM_PADS-1:0]   pad_si;
  logic [NUM_OBS-1:0]    obs_si;

  assign mode     = bscan_mode_e'(mode_sel);
  assign scan_out = chain_q[0];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    localparam int BASE = CELLS_PER_PAD * i;
    if (BASE + CELLS_PER_PAD < CHAIN_LEN) begin : g_link
      assign pad_si[i] = chain_q[BASE + CELLS_PER_PAD];
    end else begin : g_head
      assign pad_si[i] = scan_in;
    end

    bscan_pad_cells u_cells (
      .tck        (tck),
      .rst        (rst),
      .mode       (mode),
      .capture_dr (capture_dr),
      .shift_dr   (shift_dr),
      .update_dr  (update_dr),
      .chain_in   (pad_si[i]),
      .pull_swap  (pull_swap),
      .core_out   (core_out[i]),
      .core_oe    (core_oe[i]),
      .core_in    (core_in[i]),
      .pad_out    (pad_out[i]),
      .pad_oe     (pad_oe[i]),
      .pad_in     (pad_in[i]),
      .pull_up    (pad_pull_up[i]),
      .pull_dn    (pad_pull_dn[i]),
      .cell_q     (chain_q[BASE +: CELLS_PER_PAD])
    );
  end

  for (genvar j = 0; j < NUM_OBS; j++) begin : g_obs
    localparam int POS = PAD_CELLS + j;
    if (POS + 1 < CHAIN_LEN) begin : g_link
      assign obs_si[j] = chain_q[POS + 1];
    end else begin : g_head
      assign obs_si[j] = scan_in;
    end

    bscan_obs_cell u_obs (
      .tck        (tck),
      .rst        (rst),
      .capture_dr (capture_dr),
      .shift_dr   (shift_dr),
      .chain_in   (obs_si[j]),
      .obs_pin    (obs_pin[j]),
      .cell_q     (chain_q[POS])
    );
  end

endmodule

// File: rtl/bscan_io_segment_chk.sv
`timescale 1ns/1ps
module bscan_io_segment_chk #(
  parameter int NUM_PADS = 4,
  parameter int NUM_OBS  = 2
) (
  input logic                                 tck,
  input logic                                 rst,
  input logic [1:0]                           mode_sel,
  input logic                                 capture_dr,
  input logic                                 shift_dr,
  input logic                                 update_dr,
  input logic                                 scan_in,
  input logic                                 pull_swap,
  input logic [NUM_PADS-1:0]                  core_out,
  input logic [NUM_PADS-1:0]                  core_oe,
  input logic [NUM_PADS-1:0]                  core_in,
  input logic [NUM_PADS-1:0]                  pad_out,
  input logic [NUM_PADS-1:0]                  pad_oe,
  input logic [NUM_PADS-1:0]                  pad_in,
  input logic [NUM_PADS-1:0]                  pad_pull_up,
  input logic [NUM_PADS-1:0]                  pad_pull_dn,
  input logic [NUM_OBS-1:0]                   obs_pin,
  input logic [3*NUM_PADS+NUM_OBS-1:0]        chain_q
);

  localparam int L = 3 * NUM_PADS + NUM_OBS;

  AST_SHIFT_MOVES_DOWN: assert property (@(posedge tck) disable iff (rst)
    (shift_dr && !capture_dr) |=> (chain_q == {$past(scan_in), $past(chain_q[L-1:1])})); // R1

  AST_RESET_PADS_OFF: assert property (@(posedge tck) disable iff (rst)
    ($past(rst) && !$past(update_dr) && mode_sel[1]) |-> (pad_oe == '0)); // R2

  AST_PASS_THROUGH: assert property (@(posedge tck) disable iff (rst)
    !mode_sel[1] |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in)); // R3

  AST_PULL_EXCLUSIVE: assert property (@(posedge tck) disable iff (rst)
    ((pad_pull_up & pad_oe) == '0) && ((pad_pull_dn & pad_oe) == '0)
    && ((pad_pull_up | pad_pull_dn | pad_oe) == '1)); // R9

  AST_PULL_POLARITY: assert property (@(posedge tck) disable iff (rst)
    pull_swap |-> (pad_pull_dn == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (rst)
    (!capture_dr && !shift_dr) |=> $stable(chain_q)); // R11

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad_chk
    AST_EXTEST_KEEP_DRIVE: assert property (@(posedge tck) disable iff (rst)
      (capture_dr && mode_sel == 2'b10) |=>
        (chain_q[3*i] == $past(chain_q[3*i]) && chain_q[3*i+1] == $past(chain_q[3*i+1])
         && chain_q[3*i+2] == $past(pad_in[i]))); // R5

    AST_INTEST_KEEP_SENSE: assert property (@(posedge tck) disable iff (rst)
      (capture_dr && mode_sel == 2'b11) |=>
        (chain_q[3*i+2] == $past(chain_q[3*i+2]) && chain_q[3*i] == !$past(core_oe[i])
         && chain_q[3*i+1] == $past(core_out[i]))); // R6
  end

  for (genvar j = 0; j < NUM_OBS; j++) begin : g_obs_chk
    AST_OBS_CAPTURE: assert property (@(posedge tck) disable iff (rst)
      capture_dr |=> (chain_q[3*NUM_PADS+j] == $past(obs_pin[j]))); // R10
  end

endmodule

bind bscan_io_segment bscan_io_segment_chk #(
  .NUM_PADS (NUM_PADS),
  .NUM_OBS  (NUM_OBS)
) u_chk (
  .tck         (tck),
  .rst         (rst),
  .mode_sel    (mode_sel),
  .capture_dr  (capture_dr),
  .shift_dr    (shift_dr),
  .update_dr   (update_dr),
  .scan_in     (scan_in),
  .pull_swap   (pull_swap),
  .core_out    (core_out),
  .core_oe     (core_oe),
  .core_in     (core_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_in      (pad_in),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .obs_pin     (obs_pin),
  .chain_q     (chain_q)
);

// File: tb/bscan_io_segment_tb.sv
`timescale 1ns/1ps
module bscan_io_segment_tb;

  localparam int NP = 4;
  localparam int NO = 2;
  localparam int L  = 3 * NP + NO;

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'b00;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic          update_dr = 1'b0;
  logic          scan_in = 1'b0;
  logic          scan_out;
  logic          pull_swap = 1'b0;
  logic [NP-1:0] core_out = '0;
  logic [NP-1:0] core_oe = '0;
  logic [NP-1:0] core_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_pull_up;
  logic [NP-1:0] pad_pull_dn;
  logic [NO-1:0] obs_pin = '0;

  logic [L-1:0]  m_sr;
  logic [L-1:0]  m_upd;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #2 tck = ~tck;

  bscan_io_segment #(.NUM_PADS(NP), .NUM_OBS(NO)) u_dut (
    .tck(tck), .rst(rst), .mode_sel(mode_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .scan_in(scan_in),
    .scan_out(scan_out), .pull_swap(pull_swap), .core_out(core_out),
    .core_oe(core_oe), .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .obs_pin(obs_pin)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [L-1:0] pattern(input int p);
    logic [31:0] t;
    t = p * 32'h2545F491 + 32'h0000_6A5D;
    return t[L-1:0] ^ t[31:32-L];
  endfunction

  function automatic logic [L-1:0] safe_chain();
    logic [L-1:0] v = '0;
    for (int i = 0; i < NP; i++) v[3*i] = 1'b1;
    return v;
  endfunction

  // Capture as the requirements define it, per mode.
  task automatic model_capture();
    for (int i = 0; i < NP; i++) begin
      if (mode_sel != 2'b10) begin
        m_sr[3*i]   = ~core_oe[i];
        m_sr[3*i+1] = core_out[i];
      end
      if (mode_sel != 2'b11) m_sr[3*i+2] = pad_in[i];
    end
    for (int j = 0; j < NO; j++) m_sr[3*NP+j] = obs_pin[j];
  endtask

  // One test-clock period: strobes held over a falling and a rising edge.
  task automatic tick(input bit cap, input bit sh, input bit up, input bit si);
    capture_dr = cap; shift_dr = sh; update_dr = up; scan_in = si;
    @(posedge tck); #1;
    if (up) m_upd = m_sr;
    if (cap) model_capture();
    else if (sh) m_sr = {si, m_sr[L-1:1]};
    capture_dr = 0; shift_dr = 0; update_dr = 0; scan_in = 0;
  endtask

  task automatic shift_all(input logic [L-1:0] din, input string req);
    for (int k = 0; k < L; k++) begin
      chk(scan_out === m_sr[0], req, {31'd0, scan_out}, {31'd0, m_sr[0]});
      tick(0, 1, 0, din[k]);
    end
  endtask

  task automatic chk_pads(input string req);
    logic [NP-1:0] e_oe, e_out, e_in;
    bit tst;
    tst = mode_sel[1];
    for (int i = 0; i < NP; i++) begin
      e_oe[i]  = tst ? ~m_upd[3*i] : core_oe[i];
      e_out[i] = tst ? m_upd[3*i+1] : core_out[i];
      e_in[i]  = (mode_sel == 2'b11) ? m_upd[3*i+2] : pad_in[i];
    end
    chk(pad_oe === e_oe, req, 32'(pad_oe), 32'(e_oe));
    chk(pad_out === e_out, req, 32'(pad_out), 32'(e_out));
    chk(core_in === e_in, {req, "/R8"}, 32'(core_in), 32'(e_in));
    chk(pad_pull_up === (~e_oe & {NP{pull_swap}}), {req, "/R9"}, 32'(pad_pull_up), 32'(~e_oe & {NP{pull_swap}}));
    chk(pad_pull_dn === (~e_oe & {NP{~pull_swap}}), {req, "/R9"}, 32'(pad_pull_dn), 32'(~e_oe & {NP{~pull_swap}}));
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Reset: controls safe, pads undriven in test modes (R2)
    rst = 1'b1; mode_sel = 2'b10; core_oe = '1;
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;
    m_sr = safe_chain(); m_upd = safe_chain();
    chk(pad_oe === '0, "R2 pads off after reset", 32'(pad_oe), 32'd0);
    chk_pads("R2");
    shift_all(pattern(1), "R2/R1 reset chain");

    // Pass-through sweep in functional and sample modes (R3)
    for (int v = 0; v < 256; v++) begin
      @(posedge tck); #1;
      mode_sel = {1'b0, v[0]};
      core_out = v[3:0]; core_oe = v[7:4]; pad_in = ~v[5:2];
      pull_swap = v[6];
      #1 chk_pads("R3");
    end

    // Sample capture of system values and capture-only pins (R4, R10, R1)
    for (int p = 0; p < 8; p++) begin
      mode_sel = (p % 2 == 0) ? 2'b01 : 2'b00;
      core_out = 4'(p * 5); core_oe = 4'(p * 3 + 1); pad_in = 4'(p * 7 + 2);
      obs_pin = 2'(p);
      tick(1, 0, 0, 0);
      shift_all(pattern(p + 10), "R4/R10/R1 sample capture");
    end

    // External test: stage, update, drive, selective capture (R7, R5, R9, R10)
    mode_sel = 2'b10;
    for (int p = 0; p < 8; p++) begin
      shift_all(pattern(p + 20), "R5 extest shift");
      chk_pads("R7 no update during shift");
      tick(0, 0, 1, 0);
      pull_swap = 1'b0; #0 chk_pads("R7 extest drive");
      pull_swap = 1'b1; #1 chk_pads("R9 swapped pulls");
      pad_in = 4'(p * 9 + 3); core_out = ~4'(p); core_oe = 4'(p * 11);
      obs_pin = 2'(p + 1);
      tick(1, 0, 0, 0);
      shift_all(pattern(p + 30), "R5/R10 extest capture");
    end

    // Internal test: core sees latches, input cells hold on capture (R6, R8)
    mode_sel = 2'b11;
    for (int p = 0; p < 8; p++) begin
      shift_all(pattern(p + 40), "R6 intest shift");
      tick(0, 0, 1, 0);
      pad_in = 4'(p * 13 + 5);
      #0 chk_pads("R8 intest core input");
      core_out = 4'(p * 3); core_oe = ~4'(p * 5);
      tick(1, 0, 0, 0);
      shift_all(pattern(p + 50), "R6 intest capture");
    end

    // Idle cycles leave the chain alone (R11)
    mode_sel = 2'b01;
    repeat (5) tick(0, 0, 0, 1);
    shift_all(pattern(60), "R11 idle hold");
    chk_pads("R3 after idle");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule